// File: doc/BRIEF.md
# Parallel Prefix Tree Adder

A combinational adder for two W-bit operands and a carry-in. It returns a W-bit sum and a carry-out. The carries do not ripple from one bit to the next. Each bit position first forms its own generate term (the AND of the two operand bits) and its own propagate term (their XOR). A tree of group combine cells then merges these terms into prefix generates. A final XOR stage forms the sum bits.

The carry-in is treated as an extra position below operand bit 0. Its generate is the carry-in and its propagate is zero, so the prefix at each position already includes the incoming carry. The parameter TOPO selects one of three prefix networks:

- 0 selects Kogge-Stone: log2 W levels, fanout at most two.
- 1 selects Sklansky: log2 W levels, with fanout that grows toward the last level.
- 2 selects Brent-Kung: 2·log2 W − 1 levels, fanout at most two, roughly 2W cells.

Every setting gives the same arithmetic result. W may be any power of two from 4 to 64.

Top module: `pp_adder`

## Requirements
- R1: With TOPO=0 (Kogge-Stone), {c_out, sum_o} equals op_a + op_b + c_in for every input.
- R2: With TOPO=1 (Sklansky), {c_out, sum_o} equals op_a + op_b + c_in for every input.
- R3: With TOPO=2 (Brent-Kung), {c_out, sum_o} equals op_a + op_b + c_in for every input.
- R4: op_a all ones, op_b zero and c_in=1 gives sum_o all zeros and c_out=1, because the carry-in travels the full width.
- R5: When op_b is the bitwise inverse of op_a and c_in=0, sum_o is all ones and c_out is 0, because every position propagates and none generates.
- R6: When both operand MSBs are 1, c_out is 1 whatever the other bits are.
- R7: When both operand MSBs are 0, c_out is 0 whatever the other bits are.
- R8: The results of R1 to R3 hold at widths 8, 16 and 64, with no change to the source.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | W | First operand |
| op_b | input | W | Second operand |
| c_in | input | 1 | Carry into bit 0 |
| sum_o | output | W | Sum bits |
| c_out | output | 1 | Carry out of bit W−1 |

## Verification
At 8 bits, every operand pair is applied with both carry-in values. This exposes any prefix cell that is wired to the wrong partner, in any of the three networks.

At 16 and 64 bits, random vectors cover the long spans that exhaustive testing cannot reach.

The directed cases separate the group behaviours:
- All ones plus carry-in is a carry chain across the full width.
- Complementary operands propagate at every position with no generate, so they test propagate handling apart from generate.
- Both MSBs set, or both clear, confirm that the top position generates or kills the carry-out regardless of the lower prefix.

// File: rtl/pp_adder.sv
module pp_adder #(
  parameter int W    = 16,
  parameter int TOPO = 0
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         c_in,
  output logic [W-1:0] sum_o,
  output logic         c_out
);
  localparam int L  = $clog2(W);
  localparam int ST = (TOPO == 2) ? 2 * L - 1 : L;

  function automatic int src_of(int t, int s, int i);
    int d;
    int l;
    if (t == 0) begin
      d = 1 << s;
      return (i >= d) ? i - d : -1;
    end else if (t == 1) begin
      if (((i >> s) & 1) == 1) return ((i >> (s + 1)) << (s + 1)) + (1 << s) - 1;
      return -1;
    end else if (s < L) begin
      d = 1 << s;
      return ((i + 1) % (2 * d) == 0) ? i - d : -1;
    end else begin
      l = 2 * L - 2 - s;
      d = 1 << l;
      return (((i + 1) % (2 * d) == d) && (i >= 2 * d)) ? i - d : -1;
    end
  endfunction

  logic [W:0] bg, bp;
  assign bg = {op_a & op_b, c_in};
  assign bp = {op_a ^ op_b, 1'b0};

  logic [ST:0][W-1:0]   gs;
  logic [ST-1:0][W-1:0] ps;
  assign gs[0] = bg[W-1:0];
  assign ps[0] = bp[W-1:0];

  for (genvar s = 0; s < ST; s++) begin : g_lvl
    for (genvar i = 0; i < W; i++) begin : g_bit
      localparam int J = src_of(TOPO, s, i);
      if (J >= 0) begin : g_cell
        assign gs[s+1][i] = gs[s][i] | (ps[s][i] & gs[s][J]);
        if (s + 1 < ST) begin : g_p
          assign ps[s+1][i] = ps[s][i] & ps[s][J];
        end
      end else begin : g_pass
        assign gs[s+1][i] = gs[s][i];
        if (s + 1 < ST) begin : g_p
          assign ps[s+1][i] = ps[s][i];
        end
      end
    end
  end

  logic unused_top_p;
  assign unused_top_p = ^ps[ST-1];

  assign sum_o = bp[W:1] ^ gs[ST];
  assign c_out = bg[W] | (bp[W] & gs[ST][W-1]);
endmodule

// File: rtl/pp_adder_chk.sv
module pp_adder_chk #(
  parameter int W = 16
) (
  input logic [W-1:0] op_a,
  input logic [W-1:0] op_b,
  input logic         c_in,
  input logic [W-1:0] sum_o,
  input logic         c_out
);
  always_comb begin
    p_sum_matches_r1: assert ({c_out, sum_o} == ({1'b0, op_a} + {1'b0, op_b} + {{W{1'b0}}, c_in}));
    if (op_a == '1 && op_b == '0 && c_in)
      p_carry_chain_r4: assert (c_out && sum_o == '0);
    if (op_b == ~op_a && !c_in)
      p_full_prop_r5: assert (!c_out && sum_o == '1);
    if (op_a[W-1] && op_b[W-1])
      p_msb_gen_r6: assert (c_out);
    if (!op_a[W-1] && !op_b[W-1])
      p_msb_kill_r7: assert (!c_out);
  end
endmodule

bind pp_adder pp_adder_chk #(.W(W)) u_chk (.*);

// File: tb/tb_pp_adder.sv
`timescale 1ns/1ps
module tb_pp_adder;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0;
  int bad = 0;
  bit done = 0;

  logic [7:0]  a8, b8;   logic c8;
  logic [15:0] a16, b16; logic c16;
  logic [63:0] a64, b64; logic c64;
  logic [7:0]  s8k, s8s, s8b;    logic o8k, o8s, o8b;
  logic [15:0] s16k, s16s, s16b; logic o16k, o16s, o16b;
  logic [63:0] s64k, s64s, s64b; logic o64k, o64s, o64b;

  pp_adder #(.W(8),  .TOPO(0)) u8k  (.op_a(a8),  .op_b(b8),  .c_in(c8),  .sum_o(s8k),  .c_out(o8k));
  pp_adder #(.W(8),  .TOPO(1)) u8s  (.op_a(a8),  .op_b(b8),  .c_in(c8),  .sum_o(s8s),  .c_out(o8s));
  pp_adder #(.W(8),  .TOPO(2)) u8b  (.op_a(a8),  .op_b(b8),  .c_in(c8),  .sum_o(s8b),  .c_out(o8b));
  pp_adder #(.W(16), .TOPO(0)) dut  (.op_a(a16), .op_b(b16), .c_in(c16), .sum_o(s16k), .c_out(o16k));
  pp_adder #(.W(16), .TOPO(1)) u16s (.op_a(a16), .op_b(b16), .c_in(c16), .sum_o(s16s), .c_out(o16s));
  pp_adder #(.W(16), .TOPO(2)) u16b (.op_a(a16), .op_b(b16), .c_in(c16), .sum_o(s16b), .c_out(o16b));
  pp_adder #(.W(64), .TOPO(0)) u64k (.op_a(a64), .op_b(b64), .c_in(c64), .sum_o(s64k), .c_out(o64k));
  pp_adder #(.W(64), .TOPO(1)) u64s (.op_a(a64), .op_b(b64), .c_in(c64), .sum_o(s64s), .c_out(o64s));
  pp_adder #(.W(64), .TOPO(2)) u64b (.op_a(a64), .op_b(b64), .c_in(c64), .sum_o(s64b), .c_out(o64b));

  function automatic logic [64:0] ref_sum(int w, logic [63:0] a, logic [63:0] b, logic ci);
    logic [64:0] m;
    m = (w == 64) ? {65{1'b1}} : ((65'd1 << (w + 1)) - 65'd1);
    return ({1'b0, a} + {1'b0, b} + {64'd0, ci}) & m;
  endfunction

  task automatic chk(input string tag, input int w, input logic [64:0] act, input logic [64:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s w=%0d act=%h exp=%h", tag, w, act, exp);
    end
  endtask

  task automatic step8(input string tg);
    logic [64:0] e;
    #1;
    e = ref_sum(8, {56'd0, a8}, {56'd0, b8}, c8);
    chk({tg, " R1 R8"}, 8, {56'd0, o8k, s8k}, e);
    chk({tg, " R2 R8"}, 8, {56'd0, o8s, s8s}, e);
    chk({tg, " R3 R8"}, 8, {56'd0, o8b, s8b}, e);
  endtask

  task automatic step16(input string tg);
    logic [64:0] e;
    #1;
    e = ref_sum(16, {48'd0, a16}, {48'd0, b16}, c16);
    chk({tg, " R1"}, 16, {48'd0, o16k, s16k}, e);
    chk({tg, " R2"}, 16, {48'd0, o16s, s16s}, e);
    chk({tg, " R3"}, 16, {48'd0, o16b, s16b}, e);
  endtask

  task automatic step64(input string tg);
    logic [64:0] e;
    #1;
    e = ref_sum(64, a64, b64, c64);
    chk({tg, " R1 R8"}, 64, {o64k, s64k}, e);
    chk({tg, " R2 R8"}, 64, {o64s, s64s}, e);
    chk({tg, " R3 R8"}, 64, {o64b, s64b}, e);
  endtask

  task automatic corner16(input logic [15:0] a, input logic [15:0] b, input logic ci, input string tg);
    a16 = a; b16 = b; c16 = ci;
    step16(tg);
  endtask

  task automatic corner64(input logic [63:0] a, input logic [63:0] b, input logic ci, input string tg);
    a64 = a; b64 = b; c64 = ci;
    step64(tg);
  endtask

  initial begin
    a8 = '0; b8 = '0; c8 = 1'b0;
    a16 = '0; b16 = '0; c16 = 1'b0;
    a64 = '0; b64 = '0; c64 = 1'b0;
    void'($urandom(32'd2024));
    #1;
    chk("zero R1", 16, {48'd0, o16k, s16k}, 65'd0);

    corner16(16'hFFFF, 16'h0000, 1'b1, "chain R4");
    chk("chain R4 direct", 16, {48'd0, o16b, s16b}, {48'd0, 1'b1, 16'h0000});
    corner16(16'hA5A5, 16'h5A5A, 1'b0, "prop R5");
    chk("prop R5 direct", 16, {48'd0, o16s, s16s}, {48'd0, 1'b0, 16'hFFFF});
    corner16(16'hAAAA, 16'h5555, 1'b1, "prop R5 cin");
    corner16(16'h8000, 16'h8000, 1'b0, "gen R6");
    chk("gen R6 cout", 16, {64'd0, o16k}, 65'd1);
    corner16(16'h7FFF, 16'h7FFF, 1'b1, "kill R7");
    chk("kill R7 cout", 16, {64'd0, o16b}, 65'd0);
    corner16(16'hFFFF, 16'hFFFF, 1'b1, "ones R6");
    corner64('1, '0, 1'b1, "chain R4");
    corner64({32{2'b10}}, {32{2'b01}}, 1'b0, "prop R5");
    corner64({1'b1, 63'd0}, {1'b1, 63'd5}, 1'b0, "gen R6");
    corner64({1'b0, {63{1'b1}}}, {1'b0, {63{1'b1}}}, 1'b1, "kill R7");

    for (int x = 0; x < 256; x++) begin
      for (int y = 0; y < 256; y++) begin
        for (int c = 0; c < 2; c++) begin
          a8 = x[7:0]; b8 = y[7:0]; c8 = c[0];
          step8("exh");
        end
      end
    end

    for (int n = 0; n < 3000; n++) begin
      a16 = 16'($urandom); b16 = 16'($urandom); c16 = 1'($urandom);
      step16("rnd");
      a64 = {$urandom, $urandom}; b64 = {$urandom, $urandom}; c64 = 1'($urandom);
      if (n % 7 == 0) b64 = ~a64;
      step64("rnd");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      bad++;
      $display("FAIL watchdog R1 act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule